// File: doc/BRIEF.md
# Keypad matrix scan controller

This block scans a matrix of up to sixteen rows by sixteen columns of switches and keeps one 16-bit snapshot word per row that software reads over a simple register bus. Rows are driven active-low one at a time. A column input reads 0 when the key at the crossing of the driven row and that column is closed. A programmable settle count is waited before each row is sampled. In continuous operation, a programmable idle gap separates two scans.

Four operating modes are selectable. Idle drives every row high. Any-key detect drives every row low and raises a sticky status flag while any key is held, without touching the snapshot words. Single scan walks the active rows once and then sets its mode field back to idle. Continuous scan repeats the walk after each gap. Three status flags (scan complete, snapshot changed, key seen in detect mode) are cleared by writing ones, and are gated by a mask into one interrupt line.

The sequencer is a four-state machine. ST_IDLE moves to ST_DETECT in mode 1 and to ST_SETTLE in modes 2 and 3. ST_SETTLE samples the current row once its settle count expires, then moves to the next active row. After the last active row it goes to ST_GAP in mode 3 and to ST_IDLE otherwise. ST_GAP returns to ST_SETTLE at row 0 once the gap count expires. ST_DETECT returns to ST_IDLE when the mode changes. Any write to the control register forces ST_IDLE, which aborts a scan in progress.

Top module: `kpd_scan_ctrl`

## Requirements
- R1: After reset, the mode field reads 0, the status and mask registers read 0, every row snapshot reads 16'hFFFF, every row drive output is 1 and irq is 0.
- R2: In mode 1 (control bits 1:0 = 1), every row drive output is 0. Any column input at 0 sets status bit 2. A clearing write to bit 2 has no effect while a key is held, but the same write clears the bit once every column reads 1. No snapshot word changes in mode 1.
- R3: Control bits 15:2 hold the settle count S. In mode 2, with N active rows, the mode field reads 0 exactly 1+N*(S+1) clock edges after the edge that wrote the control register.
- R4: In mode 3, control bits 31:16 hold the gap count G. Between two scans, all row drives stay at 1 for exactly G+1 cycles, and scanning repeats so that snapshots follow key changes.
- R5: The register at offset 0x04 holds the row count in bits 7:0. Rows with index at or above that count keep their previous snapshot. A count above 16 acts as 16.
- R6: Register 0x04 bits 15:8 hold the column count. In every updated snapshot, bits at or above the column count read 1. Bits below it read 0 exactly where a key is pressed.
- R7: Status bit 0 is set when a scan completes. Status bit 1 is set only when some row written in that scan differs from its previous snapshot.
- R8: Writing the status register at offset 0x08 clears each bit written as 1 and leaves the other bits unchanged.
- R9: The mask at offset 0x0C enables each status bit onto irq. irq is 1 exactly when some status bit and its mask bit are both 1.
- R10: A write to the control register aborts any scan in progress and restarts from row 0. The R3 timing then counts from that write.
- R11: Row snapshots are read at byte offset 0x10+2*i in bits 15:0. The row drive output of the row being settled or sampled is 0, and all other row drive outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| row_drv | output | 16 | Row drive, 0 selects a row |
| col_sense | input | 16 | Column sense, 0 means key closed |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The hardest case to reach from the ports is an abort: a control write that lands in the middle of a continuous scan. The restart timing has to be measured from that write alone. The bench first starts mode 3 with a long gap and several rows, so the sequencer is somewhere inside a row settle. It then rewrites the control register to mode 2 and counts edges until the mode field clears. A keypad model in the bench closes switches against the row drives, so the column inputs respond to the row being driven. Random key patterns, row counts and column counts are then applied to single scans and compared against a bench model of the snapshot words that keeps stale rows.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_DETECT = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_CONT   = 2'd3
    } kmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DETECT,
        ST_SETTLE,
        ST_GAP
    } kstate_e;

    localparam logic [5:0] OFS_CTRL  = 6'h00;
    localparam logic [5:0] OFS_SIZE  = 6'h04;
    localparam logic [5:0] OFS_STAT  = 6'h08;
    localparam logic [5:0] OFS_MASK  = 6'h0C;
    localparam logic [5:0] OFS_DATA  = 6'h10;
    localparam int         NUM_EVT   = 3;
endpackage

// File: rtl/kpd_seq.sv
module kpd_seq
    import kpd_pkg::*;
#(
    parameter int NROWS   = 16,
    parameter int SETTLE_W = 14,
    parameter int GAP_W   = 16,
    localparam int ROW_W  = $clog2(NROWS),
    localparam int CNT_W  = (SETTLE_W > GAP_W) ? SETTLE_W : GAP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  kmode_e              mode,
    input  logic [SETTLE_W-1:0] settle,
    input  logic [GAP_W-1:0]    gap,
    input  logic [ROW_W:0]      row_lim,
    output logic [NROWS-1:0]    row_drv,
    output logic                smp_en,
    output logic [ROW_W-1:0]    smp_idx,
    output logic                scan_done,
    output logic                in_detect
);
    kstate_e          st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [ROW_W-1:0] row, row_n;
    logic [ROW_W:0]   row_next;

    assign row_next = {1'b0, row} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            row <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            row <= row_n;
        end
    end

    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        row_n     = row;
        smp_en    = 1'b0;
        scan_done = 1'b0;
        unique case (st)
            ST_IDLE: begin
                cnt_n = '0;
                row_n = '0;
                if (mode == MODE_DETECT)
                    st_n = ST_DETECT;
                else if (mode == MODE_SINGLE || mode == MODE_CONT)
                    st_n = ST_SETTLE;
            end
            ST_DETECT: begin
                if (mode != MODE_DETECT)
                    st_n = ST_IDLE;
            end
            ST_SETTLE: begin
                if (cnt == CNT_W'(settle)) begin
                    smp_en = ({1'b0, row} < row_lim);
                    cnt_n  = '0;
                    if (row_next >= row_lim || row_next == (ROW_W+1)'(NROWS)) begin
                        scan_done = 1'b1;
                        row_n     = '0;
                        st_n      = (mode == MODE_CONT) ? ST_GAP : ST_IDLE;
                    end else begin
                        row_n = row_next[ROW_W-1:0];
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt == CNT_W'(gap)) begin
                    cnt_n = '0;
                    st_n  = ST_SETTLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
        endcase
        if (restart) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
            row_n = '0;
        end
    end

    always_comb begin
        smp_idx   = row;
        in_detect = (st == ST_DETECT);
        for (int i = 0; i < NROWS; i++) begin
            if (st == ST_SETTLE)
                row_drv[i] = (row != ROW_W'(i));
            else
                row_drv[i] = (st != ST_DETECT);
        end
    end

    // R11: outside detect mode at most one row is driven low
    p_one_row_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DETECT) |-> $onehot0(~row_drv));

    // R4: the gap state never drives a row
    p_gap_rows_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> (row_drv == '1));
endmodule

// File: rtl/kpd_rowbank.sv
module kpd_rowbank #(
    parameter int NROWS = 16,
    parameter int NCOLS = 16,
    localparam int ROW_W = $clog2(NROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_idx,
    input  logic [ROW_W:0]   row_lim,
    input  logic [NCOLS-1:0] col_sense,
    input  logic [7:0]       col_lim,
    input  logic [ROW_W-1:0] rd_idx,
    output logic [NCOLS-1:0] rd_data,
    output logic             changed
);
    logic [NCOLS-1:0] snap [NROWS];
    logic [NCOLS-1:0] newv;

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        assign newv[c] = col_sense[c] | (8'(c) >= col_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NROWS; r++) snap[r] <= '1;
        end else if (wr_en) begin
            snap[wr_idx] <= newv;
        end
    end

    assign rd_data = snap[rd_idx];
    assign changed = wr_en && (snap[wr_idx] != newv);

    // R5: no write lands on a row at or beyond the active row count
    p_row_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < row_lim));
endmodule

// File: rtl/kpd_irq.sv
module kpd_irq
    import kpd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_evt,
    input  logic               clr_we,
    input  logic [NUM_EVT-1:0] clr_bits,
    input  logic               mask_we,
    input  logic [NUM_EVT-1:0] mask_in,
    output logic [NUM_EVT-1:0] status,
    output logic [NUM_EVT-1:0] mask,
    output logic               irq
);
    logic [NUM_EVT-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_evt;
            if (mask_we) mask <= mask_in;
        end
    end

    assign irq = |(status & mask);

    // R8: a one written to bit 0 clears it unless a new completion arrives
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[0] && !set_evt[0]) |=> !status[0]);

    // R2: a held key keeps bit 2 set even across a clearing write
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[2] |=> status[2]);
endmodule

// File: rtl/kpd_scan_ctrl.sv
module kpd_scan_ctrl
    import kpd_pkg::*;
#(
    parameter int NROWS = 16,
    parameter int NCOLS = 16,
    localparam int ROW_W = $clog2(NROWS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [15:0] row_drv,
    input  logic [15:0] col_sense,
    output logic        irq
);
    kmode_e           mode;
    logic [13:0]      settle;
    logic [15:0]      gap;
    logic [7:0]       rows_cfg, cols_cfg;
    logic [ROW_W:0]   row_lim;
    logic             ctrl_we, size_we, stat_we, mask_we;
    logic             smp_en, scan_done, in_detect, changed;
    logic [ROW_W-1:0] smp_idx, rd_idx;
    logic [5:0]       data_ofs;
    logic [NCOLS-1:0] rd_row;
    logic [NUM_EVT-1:0] status, mask, set_evt;

    assign ctrl_we = bus_we && bus_addr == OFS_CTRL;
    assign size_we = bus_we && bus_addr == OFS_SIZE;
    assign stat_we = bus_we && bus_addr == OFS_STAT;
    assign mask_we = bus_we && bus_addr == OFS_MASK;

    assign row_lim = (rows_cfg > 8'(NROWS)) ? (ROW_W+1)'(NROWS) : rows_cfg[ROW_W:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= MODE_IDLE;
            settle   <= '0;
            gap      <= '0;
            rows_cfg <= 8'(NROWS);
            cols_cfg <= 8'(NCOLS);
        end else begin
            if (ctrl_we) begin
                mode   <= kmode_e'(bus_wdata[1:0]);
                settle <= bus_wdata[15:2];
                gap    <= bus_wdata[31:16];
            end else if (scan_done && mode == MODE_SINGLE) begin
                mode <= MODE_IDLE;
            end
            if (size_we) begin
                rows_cfg <= bus_wdata[7:0];
                cols_cfg <= bus_wdata[15:8];
            end
        end
    end

    kpd_seq #(.NROWS(NROWS), .SETTLE_W(14), .GAP_W(16)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(ctrl_we), .mode(mode),
        .settle(settle), .gap(gap), .row_lim(row_lim), .row_drv(row_drv),
        .smp_en(smp_en), .smp_idx(smp_idx), .scan_done(scan_done),
        .in_detect(in_detect)
    );

    assign data_ofs = bus_addr - OFS_DATA;
    assign rd_idx   = data_ofs[ROW_W:1];

    kpd_rowbank #(.NROWS(NROWS), .NCOLS(NCOLS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(smp_en), .wr_idx(smp_idx),
        .row_lim(row_lim), .col_sense(col_sense[NCOLS-1:0]), .col_lim(cols_cfg),
        .rd_idx(rd_idx), .rd_data(rd_row), .changed(changed)
    );

    assign set_evt = {in_detect && (col_sense != '1), changed, scan_done};

    kpd_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_we(stat_we),
        .clr_bits(bus_wdata[NUM_EVT-1:0]), .mask_we(mask_we),
        .mask_in(bus_wdata[NUM_EVT-1:0]), .status(status), .mask(mask), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL)
            bus_rdata = {gap, settle, mode};
        else if (bus_addr == OFS_SIZE)
            bus_rdata = {16'h0, cols_cfg, rows_cfg};
        else if (bus_addr == OFS_STAT)
            bus_rdata = {29'h0, status};
        else if (bus_addr == OFS_MASK)
            bus_rdata = {29'h0, mask};
        else if (bus_addr >= OFS_DATA && data_ofs < 6'(2*NROWS))
            bus_rdata = 32'(rd_row);
    end

    // R3: a completed single scan returns the mode field to idle
    p_single_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && mode == MODE_SINGLE && !ctrl_we) |=> (mode == MODE_IDLE));

    // R2: detect mode never writes a snapshot
    p_detect_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DETECT) |-> !smp_en);

    // R10: a control write always restarts with no row selected
    p_restart_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (row_drv == '1));
endmodule

// File: tb/kpd_scan_ctrl_test.sv
module kpd_scan_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] row_drv;
    logic [15:0] col_sense;
    logic        irq;

    logic [15:0] keys [16];
    logic [15:0] expv [16];
    int checks = 0;
    int fails  = 0;
    int unsigned seed = 32'd1234;

    always #5 clk = ~clk;

    kpd_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .row_drv(row_drv),
        .col_sense(col_sense), .irq(irq)
    );

    always_comb begin
        col_sense = '1;
        for (int r = 0; r < 16; r++)
            if (!row_drv[r]) col_sense = col_sense & ~keys[r];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] row_val(input logic [15:0] k, input int cols);
        logic [15:0] v;
        for (int c = 0; c < 16; c++) v[c] = (c >= cols) ? 1'b1 : ~k[c];
        return v;
    endfunction

    task automatic wait_idle(output int n);
        logic [31:0] d;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            bread(6'h00, d);
        end while (d[1:0] != 2'd0 && n < 20000);
    endtask

    task automatic check_rows(input string tag);
        logic [31:0] d;
        for (int r = 0; r < 16; r++) begin
            bread(6'(16 + 2*r), d);
            check(d[15:0] == expv[r], tag, d[15:0], expv[r]);
        end
    endtask

    function automatic bit model_scan(input int rows, input int cols);
        bit ch = 0;
        int lim = (rows > 16) ? 16 : rows;
        for (int r = 0; r < lim; r++) begin
            if (expv[r] != row_val(keys[r], cols)) ch = 1;
            expv[r] = row_val(keys[r], cols);
        end
        return ch;
    endfunction

    initial begin
        #1400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n, run;
        bit ch;
        for (int r = 0; r < 16; r++) begin keys[r] = '0; expv[r] = 16'hFFFF; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        bread(6'h00, d); check(d[1:0] == 0, "R1 mode", d[1:0], 0);
        bread(6'h08, d); check(d == 0, "R1 status", d, 0);
        bread(6'h0C, d); check(d == 0, "R1 mask", d, 0);
        check(row_drv == 16'hFFFF && irq == 0, "R1 rows/irq", row_drv, 16'hFFFF);
        rst_n = 1'b1;
        check_rows("R1 snapshots");

        // R3 R6 R11 single scan timing and content
        keys[0] = 16'h0005; keys[3] = 16'h8100;
        bwrite(6'h04, {16'h0, 8'd16, 8'd4});
        bwrite(6'h00, {16'd0, 14'd3, 2'd2});
        wait_idle(n);
        check(n == 1 + 4*4, "R3 single scan cycles", n, 17);
        ch = model_scan(4, 16);
        check_rows("R11 R6 single scan rows");
        bread(6'h08, d);
        check(d[1:0] == 2'b11, "R7 done+changed", d[1:0], 3);

        // R8 clear only bit 1, then bit 0
        bwrite(6'h08, 32'h2);
        bread(6'h08, d); check(d[1:0] == 2'b01, "R8 partial clear", d[1:0], 1);
        bwrite(6'h08, 32'h7);
        bread(6'h08, d); check(d == 0, "R8 full clear", d, 0);

        // R7 identical rescan: no change flag
        bwrite(6'h00, {16'd0, 14'd0, 2'd2});
        wait_idle(n);
        bread(6'h08, d); check(d[1:0] == 2'b01, "R7 no change", d[1:0], 1);

        // R9 mask and irq
        bwrite(6'h0C, 32'h1);
        @(negedge clk); check(irq == 1, "R9 irq on", irq, 1);
        bwrite(6'h0C, 32'h6);
        @(negedge clk); check(irq == 0, "R9 irq masked", irq, 0);
        bwrite(6'h08, 32'h7);

        // R5 row clamp: count 20 acts as 16
        bwrite(6'h04, {16'h0, 8'd16, 8'd20});
        keys[15] = 16'h4000;
        bwrite(6'h00, {16'd0, 14'd1, 2'd2});
        wait_idle(n);
        check(n == 1 + 16*2, "R5 clamp cycles", n, 33);
        ch = model_scan(20, 16);
        check_rows("R5 clamp rows");

        // R2 detect mode
        bwrite(6'h08, 32'h7);
        for (int r = 0; r < 16; r++) keys[r] = '0;
        bwrite(6'h00, {16'd0, 14'd0, 2'd1});
        @(negedge clk);
        check(row_drv == 16'h0000, "R2 all rows low", row_drv, 0);
        bwrite(6'h08, 32'h7);
        bread(6'h08, d); check(d[2] == 0, "R2 no key", d[2], 0);
        keys[6] = 16'h0010;
        repeat (2) @(negedge clk);
        bread(6'h08, d); check(d[2] == 1, "R2 key seen", d[2], 1);
        bwrite(6'h08, 32'h4);
        bread(6'h08, d); check(d[2] == 1, "R2 sticky while held", d[2], 1);
        keys[6] = '0;
        @(negedge clk);
        bwrite(6'h08, 32'h4);
        bread(6'h08, d); check(d[2] == 0, "R2 clears after release", d[2], 0);
        check_rows("R2 snapshots untouched");

        // R4 continuous: gap length and refresh
        bwrite(6'h04, {16'h0, 8'd16, 8'd2});
        keys[1] = 16'h0002;
        bwrite(6'h00, {16'd7, 14'd1, 2'd3});
        n = 0;
        while (row_drv[1] != 1'b0 && n < 1000) begin @(negedge clk); n++; end
        while (row_drv != 16'hFFFF && n < 2000) begin @(negedge clk); n++; end
        run = 0;
        while (row_drv == 16'hFFFF && run < 1000) begin @(negedge clk); run++; end
        check(run == 8, "R4 gap cycles", run, 8);
        keys[0] = 16'h0800;
        repeat (60) @(negedge clk);
        ch = model_scan(2, 16);
        check_rows("R4 continuous refresh");

        // R10 abort mid-scan: timing from the new write
        bwrite(6'h04, {16'h0, 8'd16, 8'd5});
        bwrite(6'h00, {16'd100, 14'd9, 2'd3});
        repeat (23) @(negedge clk);
        bwrite(6'h00, {16'd0, 14'd2, 2'd2});
        wait_idle(n);
        check(n == 1 + 5*3, "R10 abort restart cycles", n, 16);
        ch = model_scan(5, 16);
        check_rows("R10 rows after abort");

        // random single scans (R5 R6 R7)
        for (int it = 0; it < 20; it++) begin
            int rows_r, cols_r, s_r;
            rows_r = $urandom(seed + it) % 21;
            cols_r = $urandom() % 18;
            s_r    = $urandom() % 6;
            for (int r = 0; r < 16; r++) keys[r] = 16'($urandom()) & 16'($urandom());
            bwrite(6'h08, 32'h7);
            bwrite(6'h04, {16'h0, 8'(cols_r), 8'(rows_r)});
            bwrite(6'h00, {16'd0, 14'(s_r), 2'd2});
            wait_idle(n);
            ch = model_scan(rows_r, cols_r);
            check_rows("R5 R6 random rows");
            bread(6'h08, d);
            check(d[1:0] == {ch, 1'b1}, "R7 random flags", d[1:0], {ch, 1'b1});
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule